// File: doc/BRIEF.md
# Integer ALU with Set-Compare Operations

This block is the integer execution unit of a classic five-stage RISC pipeline. It is purely combinational. Each cycle it takes two operand words and a six-bit function code and returns a result word, a zero flag and a signed-overflow flag. It covers bitwise logic, add and subtract in trapping and non-trapping forms, and shifts in three flavours. It also covers ten compare operations that write a boolean into the result word.

The surrounding decode stage converts immediate-form opcodes into the same function codes before they reach this unit. Floating-point work, multiply and divide, and moves between special registers are handled elsewhere. A code outside the supported set produces a cleared result and raises a flag that the pipeline can use to take an exception.

Internally, a decoder turns the function code into a small control record. Three datapath units (adder/subtractor, barrel shifter, comparator) and the bitwise logic in the top are steered by that record. A final multiplexer picks which unit drives the result.

Top module: `int_setcmp_alu`

## Requirements
- R1: Function codes 0x24, 0x25 and 0x26 give the bitwise AND, OR and XOR of the operands.
- R2: Function codes 0x20 and 0x21 both give A plus B modulo 2^32.
- R3: Function codes 0x22 and 0x23 both give A minus B modulo 2^32.
- R4: Code 0x04 shifts A left and code 0x06 shifts A right, both filling vacated bits with zeros. The shift distance is bits 4..0 of B, and the higher bits of B are ignored.
- R5: Code 0x07 shifts A right by bits 4..0 of B and fills the vacated upper bits with copies of A bit 31.
- R6: The signed compares write 1 when their condition holds on A and B as two's-complement values, and 0 otherwise. The codes are 0x28 equal, 0x29 not-equal, 0x2A less, 0x2B greater, 0x2C less-or-equal and 0x2D greater-or-equal. Bits 31..1 of the result are always 0.
- R7: The unsigned compares write 1 or 0 in the same way, with bits 31..1 cleared. The codes are 0x3A less, 0x3B greater, 0x3C less-or-equal and 0x3D greater-or-equal.
- R8: The overflow output is 1 only for codes 0x20 and 0x22, and only when the two's-complement result overflows. It is 0 for every other code, including 0x21 and 0x23.
- R9: Any code other than those in R1 to R7 gives a result of 0 and sets the illegal-function output to 1. Every listed code leaves that output at 0.
- R10: The zero output is 1 exactly when all 32 result bits are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_code | input | 6 | Operation select |
| op_a | input | 32 | First operand, and the value that is shifted |
| op_b | input | 32 | Second operand; bits 4..0 give the shift distance |
| result | output | 32 | Operation result |
| zero | output | 1 | Result equals zero |
| overflow | output | 1 | Signed overflow on a trapping add or subtract |
| illegal_func | output | 1 | Function code not supported |

## Verification
The checks assume that the function code and both operands are fully known (no X or Z). They are skipped while any of these inputs is unknown. The bench never leaves an input floating: it drives all three inputs together from the first cycle, and every vector sets defined values. Shift vectors deliberately drive set bits above bit 4 of B, so the masking of the shift distance is exercised without leaving those bits undefined.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;

    localparam int FUNC_W = 6;

    typedef enum logic [FUNC_W-1:0] {
        FN_SLL  = 6'h04,
        FN_SRL  = 6'h06,
        FN_SRA  = 6'h07,
        FN_ADD  = 6'h20,
        FN_ADDU = 6'h21,
        FN_SUB  = 6'h22,
        FN_SUBU = 6'h23,
        FN_AND  = 6'h24,
        FN_OR   = 6'h25,
        FN_XOR  = 6'h26,
        FN_SEQ  = 6'h28,
        FN_SNE  = 6'h29,
        FN_SLT  = 6'h2A,
        FN_SGT  = 6'h2B,
        FN_SLE  = 6'h2C,
        FN_SGE  = 6'h2D,
        FN_SLTU = 6'h3A,
        FN_SGTU = 6'h3B,
        FN_SLEU = 6'h3C,
        FN_SGEU = 6'h3D
    } alu_fn_e;

    typedef enum logic [2:0] {
        UNIT_NONE,
        UNIT_LOGIC,
        UNIT_ARITH,
        UNIT_SHIFT,
        UNIT_CMP
    } alu_unit_e;

    typedef enum logic [1:0] {
        LOG_AND,
        LOG_OR,
        LOG_XOR
    } log_op_e;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_RIGHT_ZERO,
        SH_RIGHT_SIGN
    } sh_op_e;

    typedef enum logic [2:0] {
        CMP_EQ,
        CMP_NE,
        CMP_LT,
        CMP_GT,
        CMP_LE,
        CMP_GE
    } cmp_op_e;

    typedef struct packed {
        alu_unit_e unit;
        log_op_e   log_op;
        logic      sub;
        logic      trap_ovf;
        sh_op_e    sh_op;
        cmp_op_e   cmp_op;
        logic      cmp_signed;
        logic      illegal;
    } alu_ctl_t;

endpackage

// File: rtl/int_alu_decode.sv
module int_alu_decode
    import int_alu_pkg::*;
(
    input  logic [FUNC_W-1:0] func_code,
    output alu_ctl_t          ctl
);

    always_comb begin
        ctl            = '0;
        ctl.unit       = UNIT_NONE;
        ctl.log_op     = LOG_AND;
        ctl.sh_op      = SH_LEFT;
        ctl.cmp_op     = CMP_EQ;
        ctl.illegal    = 1'b0;
        unique case (func_code)
            FN_SLL:  begin ctl.unit = UNIT_SHIFT; ctl.sh_op = SH_LEFT;       end
            FN_SRL:  begin ctl.unit = UNIT_SHIFT; ctl.sh_op = SH_RIGHT_ZERO; end
            FN_SRA:  begin ctl.unit = UNIT_SHIFT; ctl.sh_op = SH_RIGHT_SIGN; end
            FN_ADD:  begin ctl.unit = UNIT_ARITH; ctl.trap_ovf = 1'b1;       end
            FN_ADDU: begin ctl.unit = UNIT_ARITH;                            end
            FN_SUB:  begin ctl.unit = UNIT_ARITH; ctl.sub = 1'b1; ctl.trap_ovf = 1'b1; end
            FN_SUBU: begin ctl.unit = UNIT_ARITH; ctl.sub = 1'b1;            end
            FN_AND:  begin ctl.unit = UNIT_LOGIC; ctl.log_op = LOG_AND;      end
            FN_OR:   begin ctl.unit = UNIT_LOGIC; ctl.log_op = LOG_OR;       end
            FN_XOR:  begin ctl.unit = UNIT_LOGIC; ctl.log_op = LOG_XOR;      end
            FN_SEQ:  begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_EQ; ctl.cmp_signed = 1'b1; end
            FN_SNE:  begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_NE; ctl.cmp_signed = 1'b1; end
            FN_SLT:  begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_LT; ctl.cmp_signed = 1'b1; end
            FN_SGT:  begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_GT; ctl.cmp_signed = 1'b1; end
            FN_SLE:  begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_LE; ctl.cmp_signed = 1'b1; end
            FN_SGE:  begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_GE; ctl.cmp_signed = 1'b1; end
            FN_SLTU: begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_LT; end
            FN_SGTU: begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_GT; end
            FN_SLEU: begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_LE; end
            FN_SGEU: begin ctl.unit = UNIT_CMP; ctl.cmp_op = CMP_GE; end
            default: begin ctl.unit = UNIT_NONE; ctl.illegal = 1'b1; end
        endcase
    end

endmodule

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  logic             sub,
    input  logic             trap_ovf,
    output logic [WIDTH-1:0] sum,
    output logic             ovf
);

    localparam int MSB = WIDTH - 1;

    logic [WIDTH-1:0] rhs_eff;
    logic             sign_clash;

    always_comb begin
        rhs_eff    = sub ? ~rhs : rhs;
        sum        = lhs + rhs_eff + WIDTH'(sub);
        sign_clash = (lhs[MSB] == rhs_eff[MSB]) && (sum[MSB] != lhs[MSB]);
        ovf        = trap_ovf && sign_clash;
    end

endmodule

// File: rtl/int_alu_shift.sv
module int_alu_shift
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int SH_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] value,
    input  logic [SH_W-1:0]  amount,
    input  sh_op_e           sh_op,
    output logic [WIDTH-1:0] shifted
);

    logic [WIDTH-1:0] value_rev;
    logic [WIDTH-1:0] stage_in;
    logic [WIDTH-1:0] stage_out;
    logic [WIDTH-1:0] stage [SH_W+1];
    logic             fill;

    // Left shifts reuse the right-shift network on a bit-reversed word.
    for (genvar i = 0; i < WIDTH; i++) begin : g_rev_in
        assign value_rev[i] = value[WIDTH-1-i];
    end

    always_comb begin
        stage_in = (sh_op == SH_LEFT) ? value_rev : value;
        fill     = (sh_op == SH_RIGHT_SIGN) ? value[WIDTH-1] : 1'b0;
    end

    assign stage[0] = stage_in;

    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        localparam int DIST = 1 << s;
        assign stage[s+1] = amount[s]
            ? {{DIST{fill}}, stage[s][WIDTH-1:DIST]}
            : stage[s];
    end

    assign stage_out = stage[SH_W];

    for (genvar i = 0; i < WIDTH; i++) begin : g_rev_out
        assign shifted[i] = (sh_op == SH_LEFT) ? stage_out[WIDTH-1-i] : stage_out[i];
    end

endmodule

// File: rtl/int_alu_compare.sv
module int_alu_compare
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] lhs,
    input  logic [WIDTH-1:0] rhs,
    input  cmp_op_e          cmp_op,
    input  logic             cmp_signed,
    output logic             holds
);

    logic is_eq;
    logic is_lt;
    logic is_gt;

    always_comb begin
        is_eq = (lhs == rhs);
        is_lt = cmp_signed ? ($signed(lhs) < $signed(rhs)) : (lhs < rhs);
        is_gt = !is_lt && !is_eq;
        unique case (cmp_op)
            CMP_EQ:  holds = is_eq;
            CMP_NE:  holds = !is_eq;
            CMP_LT:  holds = is_lt;
            CMP_GT:  holds = is_gt;
            CMP_LE:  holds = !is_gt;
            CMP_GE:  holds = !is_lt;
            default: holds = 1'b0;
        endcase
    end

endmodule

// File: rtl/int_setcmp_alu.sv
module int_setcmp_alu
    import int_alu_pkg::*;
#(
    parameter int WIDTH = 32
) (
    input  logic [FUNC_W-1:0] func_code,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    output logic [WIDTH-1:0]  result,
    output logic              zero,
    output logic              overflow,
    output logic              illegal_func
);

    localparam int SH_W = $clog2(WIDTH);

    alu_ctl_t         ctl;
    logic [WIDTH-1:0] arith_res;
    logic             arith_ovf;
    logic [WIDTH-1:0] shift_res;
    logic             cmp_holds;
    logic [WIDTH-1:0] logic_res;

    int_alu_decode u_decode (
        .func_code (func_code),
        .ctl       (ctl)
    );

    int_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
        .lhs      (op_a),
        .rhs      (op_b),
        .sub      (ctl.sub),
        .trap_ovf (ctl.trap_ovf),
        .sum      (arith_res),
        .ovf      (arith_ovf)
    );

    int_alu_shift #(.WIDTH(WIDTH)) u_shift (
        .value   (op_a),
        .amount  (op_b[SH_W-1:0]),
        .sh_op   (ctl.sh_op),
        .shifted (shift_res)
    );

    int_alu_compare #(.WIDTH(WIDTH)) u_compare (
        .lhs        (op_a),
        .rhs        (op_b),
        .cmp_op     (ctl.cmp_op),
        .cmp_signed (ctl.cmp_signed),
        .holds      (cmp_holds)
    );

    always_comb begin
        unique case (ctl.log_op)
            LOG_AND: logic_res = op_a & op_b;
            LOG_OR:  logic_res = op_a | op_b;
            LOG_XOR: logic_res = op_a ^ op_b;
            default: logic_res = '0;
        endcase
    end

    always_comb begin
        overflow = 1'b0;
        unique case (ctl.unit)
            UNIT_LOGIC: result = logic_res;
            UNIT_ARITH: begin
                result   = arith_res;
                overflow = arith_ovf;
            end
            UNIT_SHIFT: result = shift_res;
            UNIT_CMP:   result = {{(WIDTH-1){1'b0}}, cmp_holds};
            default:    result = '0;
        endcase
        zero         = ~|result;
        illegal_func = ctl.illegal;
    end

endmodule

// File: rtl/int_setcmp_alu_chk.sv
module int_setcmp_alu_chk #(
    parameter int WIDTH = 32
) (
    input logic [5:0]       func_code,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] result,
    input logic             overflow,
    input logic             illegal_func
);

    localparam int SH_W = $clog2(WIDTH);
    localparam int MSB  = WIDTH - 1;

    logic known;
    assign known = !$isunknown({func_code, op_a, op_b});

    always_comb begin
        if (known) begin
            if (overflow)
                AST_NO_OVERFLOW: assert (func_code == 6'h20 || func_code == 6'h22)
                    else $error("overflow on code %h", func_code); // R8
            if (func_code == 6'h20)
                AST_ADD_OVERFLOW: assert (overflow ==
                    ((op_a[MSB] == op_b[MSB]) && (result[MSB] != op_a[MSB])))
                    else $error("add overflow mismatch"); // R8
            if (func_code inside {6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2C, 6'h2D})
                AST_SIGNED_SET_BINARY: assert (result[MSB:1] == '0)
                    else $error("signed compare upper bits set"); // R6
            if (func_code inside {6'h3A, 6'h3B, 6'h3C, 6'h3D})
                AST_UNSIGNED_SET_BINARY: assert (result[MSB:1] == '0)
                    else $error("unsigned compare upper bits set"); // R7
            if (illegal_func)
                AST_ILLEGAL_CLEARS: assert (result == '0)
                    else $error("illegal code left result %h", result); // R9
            if (func_code inside {6'h04, 6'h06, 6'h07} && op_b[SH_W-1:0] == '0)
                AST_SHIFT_BY_NONE: assert (result == op_a)
                    else $error("zero-distance shift altered value"); // R4
        end
    end

endmodule

bind int_setcmp_alu int_setcmp_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .func_code    (func_code),
    .op_a         (op_a),
    .op_b         (op_b),
    .result       (result),
    .overflow     (overflow),
    .illegal_func (illegal_func)
);

// File: tb/int_setcmp_alu_bench.sv
module int_setcmp_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NV         = 43;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  func_code;
    logic [31:0] op_a;
    logic [31:0] op_b;
    logic [31:0] result;
    logic        zero;
    logic        overflow;
    logic        illegal_func;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    int_setcmp_alu u_int_setcmp_alu (
        .func_code    (func_code),
        .op_a         (op_a),
        .op_b         (op_b),
        .result       (result),
        .zero         (zero),
        .overflow     (overflow),
        .illegal_func (illegal_func)
    );

    // {func, a, b, expected result, expected overflow, expected illegal}
    localparam logic [103:0] VECS [NV] = '{
        {6'h24, 32'hF0F01234, 32'h0FF0FF00, 32'h00F01200, 1'b0, 1'b0},
        {6'h25, 32'hF0000000, 32'h0000000F, 32'hF000000F, 1'b0, 1'b0},
        {6'h26, 32'hFFFF0000, 32'hFF00FF00, 32'h00FFFF00, 1'b0, 1'b0},
        {6'h26, 32'h12345678, 32'h12345678, 32'h00000000, 1'b0, 1'b0},
        {6'h20, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b1, 1'b0},
        {6'h20, 32'h80000000, 32'h80000000, 32'h00000000, 1'b1, 1'b0},
        {6'h20, 32'h00000005, 32'hFFFFFFFD, 32'h00000002, 1'b0, 1'b0},
        {6'h21, 32'h7FFFFFFF, 32'h00000001, 32'h80000000, 1'b0, 1'b0},
        {6'h21, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
        {6'h22, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b1, 1'b0},
        {6'h22, 32'h7FFFFFFF, 32'hFFFFFFFF, 32'h80000000, 1'b1, 1'b0},
        {6'h22, 32'h0000000A, 32'h00000003, 32'h00000007, 1'b0, 1'b0},
        {6'h23, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 1'b0, 1'b0},
        {6'h23, 32'h80000000, 32'h00000001, 32'h7FFFFFFF, 1'b0, 1'b0},
        {6'h04, 32'h00000001, 32'h0000001F, 32'h80000000, 1'b0, 1'b0},
        {6'h04, 32'h80000003, 32'h00000021, 32'h00000006, 1'b0, 1'b0},
        {6'h06, 32'h80000000, 32'h00000004, 32'h08000000, 1'b0, 1'b0},
        {6'h06, 32'hABCD1234, 32'h00000000, 32'hABCD1234, 1'b0, 1'b0},
        {6'h07, 32'h80000000, 32'h00000004, 32'hF8000000, 1'b0, 1'b0},
        {6'h07, 32'h80000000, 32'h0000001F, 32'hFFFFFFFF, 1'b0, 1'b0},
        {6'h07, 32'h70000000, 32'h0000001C, 32'h00000007, 1'b0, 1'b0},
        {6'h07, 32'hF0000000, 32'hFFFFFFE4, 32'hFF000000, 1'b0, 1'b0},
        {6'h28, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
        {6'h28, 32'h00000005, 32'h00000005, 32'h00000001, 1'b0, 1'b0},
        {6'h29, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
        {6'h2A, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
        {6'h2B, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
        {6'h2C, 32'h00000005, 32'h00000005, 32'h00000001, 1'b0, 1'b0},
        {6'h2D, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
        {6'h2D, 32'h80000000, 32'h80000000, 32'h00000001, 1'b0, 1'b0},
        {6'h2A, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0},
        {6'h3A, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b0},
        {6'h3B, 32'hFFFFFFFF, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
        {6'h3C, 32'h00000001, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
        {6'h3D, 32'h00000000, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b0},
        {6'h3A, 32'h00000000, 32'h00000001, 32'h00000001, 1'b0, 1'b0},
        {6'h3B, 32'h80000000, 32'h7FFFFFFF, 32'h00000001, 1'b0, 1'b0},
        {6'h00, 32'h0000000F, 32'h0000000F, 32'h00000000, 1'b0, 1'b1},
        {6'h05, 32'h0000000F, 32'h00000001, 32'h00000000, 1'b0, 1'b1},
        {6'h27, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h00000000, 1'b0, 1'b1},
        {6'h3F, 32'h12345678, 32'h00000003, 32'h00000000, 1'b0, 1'b1},
        {6'h2E, 32'h00000001, 32'h00000001, 32'h00000000, 1'b0, 1'b1},
        {6'h30, 32'h7FFFFFFF, 32'h00000001, 32'h00000000, 1'b0, 1'b1}
    };

    function automatic string req_tag(input logic [5:0] f);
        case (f)
            6'h24, 6'h25, 6'h26:                      return "R1";
            6'h20, 6'h21:                             return "R2";
            6'h22, 6'h23:                             return "R3";
            6'h04, 6'h06:                             return "R4";
            6'h07:                                    return "R5";
            6'h28, 6'h29, 6'h2A, 6'h2B, 6'h2C, 6'h2D: return "R6";
            6'h3A, 6'h3B, 6'h3C, 6'h3D:               return "R7";
            default:                                  return "R9";
        endcase
    endfunction

    function automatic bit is_listed(input logic [5:0] f);
        return f inside {6'h04, 6'h06, 6'h07, 6'h20, 6'h21, 6'h22, 6'h23,
                         6'h24, 6'h25, 6'h26, 6'h28, 6'h29, 6'h2A, 6'h2B,
                         6'h2C, 6'h2D, 6'h3A, 6'h3B, 6'h3C, 6'h3D};
    endfunction

    task automatic check_val(input string tag, input string what,
                             input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h (code %h a %h b %h)",
                     tag, what, got, exp, func_code, op_a, op_b);
        end
    endtask

    task automatic drive(input logic [5:0] f, input logic [31:0] a, input logic [31:0] b);
        @(posedge clk);
        func_code = f;
        op_a      = a;
        op_b      = b;
        @(negedge clk);
    endtask

    task automatic run_vector(input logic [103:0] v);
        logic [5:0]  f;
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] r;
        f = v[103:98];
        a = v[97:66];
        b = v[65:34];
        r = v[33:2];
        drive(f, a, b);
        check_val(req_tag(f), "result", result, r);
        check_val("R8", "overflow", {31'b0, overflow}, {31'b0, v[1]});
        check_val("R9", "illegal", {31'b0, illegal_func}, {31'b0, v[0]});
        check_val("R10", "zero", {31'b0, zero}, {31'b0, (r == 32'h0)});
    endtask

    initial begin
        func_code = 6'h00;
        op_a      = 32'h0;
        op_b      = 32'h0;
        repeat (2) @(posedge clk);
        rst = 1'b0;
        @(negedge clk);

        // Idle state: code 0x00 is unsupported, so result is cleared
        check_val("R9", "idle result", result, 32'h0);
        check_val("R9", "idle illegal", {31'b0, illegal_func}, 32'h1);
        check_val("R10", "idle zero", {31'b0, zero}, 32'h1);
        check_val("R8", "idle overflow", {31'b0, overflow}, 32'h0);

        for (int i = 0; i < NV; i++) run_vector(VECS[i]);

        // R9: sweep every code; unlisted ones clear the result and flag illegal
        for (int c = 0; c < 64; c++) begin
            drive(6'(c), 32'hFFFFFFFF, 32'h00000001);
            check_val("R9", "illegal sweep", {31'b0, illegal_func},
                      {31'b0, !is_listed(6'(c))});
            if (!is_listed(6'(c)))
                check_val("R9", "illegal sweep result", result, 32'h0);
        end

        // R5: arithmetic right shift at every distance, upper B bits set
        for (int s = 0; s < 32; s++) begin
            logic [31:0] exp_sra;
            exp_sra = 32'($signed(32'h80000001) >>> s);
            drive(6'h07, 32'h80000001, 32'hFFFFFFE0 | 32'(s));
            check_val("R5", "sra sweep", result, exp_sra);
        end

        // R4: logical shifts at every distance
        for (int s = 0; s < 32; s++) begin
            drive(6'h04, 32'h80000001, 32'(s) | 32'h00000100);
            check_val("R4", "sll sweep", result, 32'h80000001 << s);
            drive(6'h06, 32'h80000001, 32'(s) | 32'h00000100);
            check_val("R4", "srl sweep", result, 32'h80000001 >> s);
        end

        // R8: unsigned subtract with signed-overflow operands never flags
        drive(6'h23, 32'h7FFFFFFF, 32'hFFFFFFFF);
        check_val("R8", "subu no overflow", {31'b0, overflow}, 32'h0);
        check_val("R3", "subu wrap", result, 32'h80000000);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule